// File: doc/BRIEF.md
# Scalar-Multiplier Register Front End

This block connects a 256-bit elliptic-curve base-point multiplier to a simple 32-bit host bus. The host selects a register with a chip-select, a write strobe and a 6-bit word address. It writes the scalar into an eight-word input bank and launches the engine by toggling a control bit from 0 to 1. It then polls a status flag and reads the two result coordinates from two eight-word output banks. All three banks are little-endian by word, so the least significant 32 bits of each 256-bit operand sit at the lowest address of its bank.

The engine is not part of this block. It is reached through a flat scalar output, a one-cycle start pulse, and a done input that comes with the two flat result vectors. The result banks capture those vectors in the cycle that done is high. Three constant words identify the block: two name words and a version word.

Top module: `ecmul_regfile`

## Requirements
- R1: While reset is low, and right after it is released, `rdata` and `eng_start` are 0, and reads of control (0x08), status (0x09) and every word of the three banks return 0.
- R2: Reads of 0x00, 0x01 and 0x02 return 0x65636D75, 0x6C323536 and 0x00010000.
- R3: A write to 0x20+i (i = 0..7) stores the word in scalar bank word i, which drives `eng_scalar[32*i+31:32*i]` and reads back at the same address.
- R4: `eng_start` is high for exactly one cycle, in the cycle after a control write whose bit 1 is 1 while the stored control bit 1 is 0. A control write of bit 1 = 1 while the stored bit is already 1 starts nothing. Control reads return the stored bit in bit 1.
- R5: Status bit 1 ("valid") clears in the same edge that raises `eng_start`, and is set by the edge at which `eng_done` is high.
- R6: At that same edge, 0x28+i and 0x30+i load word i of `eng_res_x` and `eng_res_y`. Host writes to these ranges leave them unchanged.
- R7: Read data appears on `rdata` one cycle after a read (`sel`=1, `wr`=0) is presented, and holds until the next read. Unmapped addresses (0x03–0x07, 0x0A–0x1F, 0x38–0x3F) read as 0.
- R8: Writes to the identification words and to status have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Bus select (read or write strobe) |
| wr | input | 1 | 1 = write, 0 = read, when sel is high |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| eng_scalar | output | 256 | Scalar bank contents, word 0 in the low bits |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_done | input | 1 | Engine completion strobe |
| eng_res_x | input | 256 | Engine X result, valid with eng_done |
| eng_res_y | input | 256 | Engine Y result, valid with eng_done |

## Verification
The hardest case to reach from the ports is a repeated launch write of 1 while the stored bit is already 1. Such a write must leave both the start pulse and the valid flag untouched. The bench reaches it after a full operation has completed: it writes the launch value a second time, then counts start pulses and reads status. It then writes 0 followed by 1 to show that the edge re-arms. A second operation with a different scalar shows that valid clears at the new launch and that both result banks are overwritten at the second done.

// File: rtl/ecmul_regs_pkg.sv
package ecmul_regs_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 6;
  localparam int OPER_WORDS = 8;

  localparam int ADR_NAME0  = 'h00;
  localparam int ADR_NAME1  = 'h01;
  localparam int ADR_VER    = 'h02;
  localparam int ADR_CTRL   = 'h08;
  localparam int ADR_STAT   = 'h09;
  localparam int ADR_BANK_K = 'h20;
  localparam int ADR_BANK_X = 'h28;
  localparam int ADR_BANK_Y = 'h30;

  localparam int GO_BIT     = 1;
  localparam int VALID_BIT  = 1;

  localparam logic [31:0] ID_NAME0 = 32'h6563_6D75;
  localparam logic [31:0] ID_NAME1 = 32'h6C32_3536;
  localparam logic [31:0] ID_VER   = 32'h0001_0000;
endpackage

// File: rtl/ecmul_oper_bank.sv
module ecmul_oper_bank #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 8,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int FLAT_W = DATA_W * WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ld_en,
  input  logic [FLAT_W-1:0] ld_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [FLAT_W-1:0] flat
);
  logic [DATA_W-1:0] word_q [WORDS];
  logic [DATA_W-1:0] word_d [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_comb begin
      word_d[i] = word_q[i];
      if (ld_en)
        word_d[i] = ld_data[i*DATA_W +: DATA_W];
      else if (wr_en && (wr_idx == IDX_W'(i)))
        word_d[i] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q[i] <= '0;
      else        word_q[i] <= word_d[i];
    end

    assign flat[i*DATA_W +: DATA_W] = word_q[i];
  end

  assign rd_data = word_q[rd_idx];

  // R6: bank contents change only through a load or a write
  a_r6_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !wr_en) |=> $stable(flat));
endmodule

// File: rtl/ecmul_launch.sv
module ecmul_launch (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic go_in,
  input  logic eng_done,
  output logic go_q,
  output logic eng_start,
  output logic valid
);
  logic go_d, start_q, start_d, valid_q, valid_d, fire;

  always_comb begin
    fire    = ctrl_wr && go_in && !go_q;
    go_d    = ctrl_wr ? go_in : go_q;
    start_d = fire;
    valid_d = valid_q;
    if (fire)          valid_d = 1'b0;
    else if (eng_done) valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q    <= 1'b0;
      start_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      go_q    <= go_d;
      start_q <= start_d;
      valid_q <= valid_d;
    end
  end

  assign eng_start = start_q;
  assign valid     = valid_q;

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  a_r4_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && ctrl_wr) |=> !eng_start);
  a_r5_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !valid);
  a_r5_set_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !ctrl_wr) |=> valid);
endmodule

// File: rtl/ecmul_regfile.sv
module ecmul_regfile
  import ecmul_regs_pkg::*;
#(
  parameter int P_DATA_W = DATA_W,
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_WORDS  = OPER_WORDS,
  localparam int IDX_W   = $clog2(P_WORDS),
  localparam int OPER_W  = P_DATA_W * P_WORDS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel,
  input  logic                wr,
  input  logic [P_ADDR_W-1:0] addr,
  input  logic [P_DATA_W-1:0] wdata,
  output logic [P_DATA_W-1:0] rdata,
  output logic [OPER_W-1:0]   eng_scalar,
  output logic                eng_start,
  input  logic                eng_done,
  input  logic [OPER_W-1:0]   eng_res_x,
  input  logic [OPER_W-1:0]   eng_res_y
);
  localparam logic [P_ADDR_W-1:0] A_K = P_ADDR_W'(ADR_BANK_K);
  localparam logic [P_ADDR_W-1:0] A_X = P_ADDR_W'(ADR_BANK_X);
  localparam logic [P_ADDR_W-1:0] A_Y = P_ADDR_W'(ADR_BANK_Y);

  logic wr_en, rd_en, k_hit, x_hit, y_hit, ctrl_wr, mapped;
  logic go_q, valid;
  logic [IDX_W-1:0]    word_idx;
  logic [P_DATA_W-1:0] k_rd, x_rd, y_rd, rd_d, rd_next, rdata_q;
  logic [OPER_W-1:0]   x_flat, y_flat;

  assign wr_en    = sel && wr;
  assign rd_en    = sel && !wr;
  assign word_idx = addr[IDX_W-1:0];
  assign k_hit    = addr[P_ADDR_W-1:IDX_W] == A_K[P_ADDR_W-1:IDX_W];
  assign x_hit    = addr[P_ADDR_W-1:IDX_W] == A_X[P_ADDR_W-1:IDX_W];
  assign y_hit    = addr[P_ADDR_W-1:IDX_W] == A_Y[P_ADDR_W-1:IDX_W];
  assign ctrl_wr  = wr_en && (addr == P_ADDR_W'(ADR_CTRL));

  ecmul_oper_bank #(.DATA_W(P_DATA_W), .WORDS(P_WORDS)) u_bank_k (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en && k_hit), .wr_idx(word_idx), .wr_data(wdata),
    .ld_en(1'b0), .ld_data('0),
    .rd_idx(word_idx), .rd_data(k_rd), .flat(eng_scalar));

  ecmul_oper_bank #(.DATA_W(P_DATA_W), .WORDS(P_WORDS)) u_bank_x (
    .clk(clk), .rst_n(rst_n),
    .wr_en(1'b0), .wr_idx(word_idx), .wr_data(wdata),
    .ld_en(eng_done), .ld_data(eng_res_x),
    .rd_idx(word_idx), .rd_data(x_rd), .flat(x_flat));

  ecmul_oper_bank #(.DATA_W(P_DATA_W), .WORDS(P_WORDS)) u_bank_y (
    .clk(clk), .rst_n(rst_n),
    .wr_en(1'b0), .wr_idx(word_idx), .wr_data(wdata),
    .ld_en(eng_done), .ld_data(eng_res_y),
    .rd_idx(word_idx), .rd_data(y_rd), .flat(y_flat));

  ecmul_launch u_launch (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(ctrl_wr), .go_in(wdata[GO_BIT]), .eng_done(eng_done),
    .go_q(go_q), .eng_start(eng_start), .valid(valid));

  always_comb begin
    rd_d   = '0;
    mapped = 1'b1;
    if (k_hit)      rd_d = k_rd;
    else if (x_hit) rd_d = x_rd;
    else if (y_hit) rd_d = y_rd;
    else begin
      case (addr)
        P_ADDR_W'(ADR_NAME0): rd_d = P_DATA_W'(ID_NAME0);
        P_ADDR_W'(ADR_NAME1): rd_d = P_DATA_W'(ID_NAME1);
        P_ADDR_W'(ADR_VER):   rd_d = P_DATA_W'(ID_VER);
        P_ADDR_W'(ADR_CTRL):  rd_d[GO_BIT] = go_q;
        P_ADDR_W'(ADR_STAT):  rd_d[VALID_BIT] = valid;
        default:              mapped = 1'b0;
      endcase
    end
    rd_next = rd_en ? rd_d : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rd_next;
  end

  assign rdata = rdata_q;

  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped) |=> (rdata == '0));
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
  a_r6_x_capture: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> (x_flat == $past(eng_res_x)));
  a_r6_y_capture: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> (y_flat == $past(eng_res_y)));
endmodule

// File: tb/ecmul_regfile_tb.sv
`timescale 1ns/1ps
module ecmul_regfile_tb;
  localparam int LAT = 20;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, sel, wr, eng_done, eng_start;
  logic [5:0] addr;
  logic [31:0] wdata, rdata;
  logic [255:0] eng_scalar, eng_res_x, eng_res_y;

  ecmul_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .eng_scalar(eng_scalar),
    .eng_start(eng_start), .eng_done(eng_done),
    .eng_res_x(eng_res_x), .eng_res_y(eng_res_y));

  int tests = 0, fails = 0, starts = 0, dones = 0;
  bit finished = 0;

  typedef struct { logic [31:0] exp; logic [5:0] a; string tag; } rd_item_t;
  rd_item_t sb_q[$];
  logic rd_flag = 1'b0;

  function automatic logic [255:0] fx(input logic [255:0] k);
    return k ^ {8{32'h5A3C_96E1}};
  endfunction
  function automatic logic [255:0] fy(input logic [255:0] k);
    return {k[127:0], k[255:128]} + 256'd1;
  endfunction

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // monitor: compare registered read data against queued expectations
  always @(posedge clk) rd_flag <= sel && !wr;
  always @(negedge clk) begin
    rd_item_t it;
    if (rd_flag === 1'b1) begin
      if (sb_q.size() == 0) check("R7 unexpected read", 256'(rdata), 256'hx);
      else begin
        it = sb_q.pop_front();
        check(it.tag, 256'(rdata), 256'(it.exp));
      end
    end
  end

  // engine stub
  always @(negedge clk) if (rst_n === 1'b1 && eng_start === 1'b1) starts++;
  initial begin
    logic [255:0] kc;
    eng_done = 0; eng_res_x = '0; eng_res_y = '0;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && eng_start === 1'b1) begin
        kc = eng_scalar;
        repeat (LAT) @(negedge clk);
        eng_res_x = fx(kc); eng_res_y = fy(kc); eng_done = 1;
        @(negedge clk);
        eng_done = 0; dones++;
      end
    end
  end

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    rd_item_t it;
    @(negedge clk); sel = 1; wr = 0; addr = a;
    it.exp = exp; it.a = a; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); sel = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [255:0] k1, k2;
    k1 = {32'h0123_4567, 32'h89AB_CDEF, 32'hFEDC_BA98, 32'h7654_3210,
          32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h1357_9BDF, 32'h2468_ACE0};
    k2 = ~k1 ^ {8{32'h0F0F_3C3C}};
    rst_n = 0; sel = 0; wr = 0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", 256'(rdata), 256'd0);
    check("R1 start in reset", 256'(eng_start), 256'd0);
    rst_n = 1;
    bus_rd(6'h08, 32'h0, "R1 control");
    bus_rd(6'h09, 32'h0, "R1 status");
    bus_rd(6'h20, 32'h0, "R1 scalar word");
    bus_rd(6'h28, 32'h0, "R1 x word");
    bus_rd(6'h37, 32'h0, "R1 y word");
    bus_rd(6'h00, 32'h6563_6D75, "R2 name0");
    bus_rd(6'h01, 32'h6C32_3536, "R2 name1");
    bus_rd(6'h02, 32'h0001_0000, "R2 version");
    bus_rd(6'h03, 32'h0, "R7 unmapped 03");
    bus_rd(6'h0A, 32'h0, "R7 unmapped 0A");
    bus_rd(6'h1F, 32'h0, "R7 unmapped 1F");
    bus_rd(6'h38, 32'h0, "R7 unmapped 38");
    bus_rd(6'h3F, 32'h0, "R7 unmapped 3F");

    for (int i = 0; i < 8; i++) bus_wr(6'h20 + 6'(i), k1[32*i +: 32]);
    for (int i = 0; i < 8; i++) bus_rd(6'h20 + 6'(i), k1[32*i +: 32], "R3 scalar readback");
    check("R3 scalar port", eng_scalar, k1);

    bus_wr(6'h08, 32'h0);
    bus_wr(6'h08, 32'h2);
    bus_rd(6'h09, 32'h0, "R5 valid low after start");
    repeat (2) @(negedge clk);
    check("R4 one start", 256'(starts), 256'd1);
    wait (dones == 1);
    bus_rd(6'h09, 32'h2, "R5 valid after done");
    bus_rd(6'h08, 32'h2, "R4 control readback");
    for (int i = 0; i < 8; i++) bus_rd(6'h28 + 6'(i), fx(k1) >> (32*i), "R6 x result");
    for (int i = 0; i < 8; i++) bus_rd(6'h30 + 6'(i), fy(k1) >> (32*i), "R6 y result");

    bus_wr(6'h08, 32'h2);
    repeat (3) @(negedge clk);
    check("R4 rewrite of 1 no start", 256'(starts), 256'd1);
    bus_rd(6'h09, 32'h2, "R4 rewrite keeps valid");

    bus_wr(6'h28, 32'hFFFF_FFFF);
    bus_wr(6'h35, 32'h1234_5678);
    bus_wr(6'h00, 32'h0);
    bus_wr(6'h02, 32'hFFFF_FFFF);
    bus_wr(6'h09, 32'h0);
    bus_rd(6'h28, fx(k1) >> 0, "R6 x write ignored");
    bus_rd(6'h35, fy(k1) >> 160, "R6 y write ignored");
    bus_rd(6'h00, 32'h6563_6D75, "R8 name0 write ignored");
    bus_rd(6'h02, 32'h0001_0000, "R8 version write ignored");
    bus_rd(6'h09, 32'h2, "R8 status write ignored");

    for (int i = 0; i < 8; i++) bus_wr(6'h20 + 6'(i), k2[32*i +: 32]);
    bus_wr(6'h08, 32'h0);
    repeat (2) @(negedge clk);
    check("R4 write 0 no start", 256'(starts), 256'd1);
    bus_wr(6'h08, 32'h2);
    bus_rd(6'h09, 32'h0, "R5 valid clears on new start");
    repeat (2) @(negedge clk);
    check("R4 rearmed start", 256'(starts), 256'd2);
    wait (dones == 2);
    bus_rd(6'h09, 32'h2, "R5 valid after second done");
    for (int i = 0; i < 8; i++) bus_rd(6'h28 + 6'(i), fx(k2) >> (32*i), "R6 x second result");
    for (int i = 0; i < 8; i++) bus_rd(6'h30 + 6'(i), fy(k2) >> (32*i), "R6 y second result");

    repeat (3) @(negedge clk);
    check("R7 all reads returned", 256'(sb_q.size()), 256'd0);
    summary();
  end
endmodule